// File: doc/BRIEF.md
# Sequencer Run Supervisor

This block sits beside a pulse-program sequencer and decides when it runs. It accepts a one-cycle software start, a one-cycle software stop, an active-low hardware trigger, an active-low hardware reset and a level that says the program store holds a complete program. It issues a run enable, a one-cycle "restart from address zero" command and a one-cycle "resume past the wait" command to the sequencer. It also drives four one-hot status lines. The sequencer reports back with single-cycle events when it reaches a wait instruction or a stop instruction.

The trigger line does different jobs depending on the state. In an idle state, reached after a stop or after a hardware reset, a trigger launches the program from its first word. While the sequencer is parked on a wait instruction, a trigger lets it continue. While the program runs normally, a trigger is ignored. The hardware reset line always pulls execution back to the beginning and leaves the block idle until the next start. The analog gate is open only while a program is active. The TTL pattern is not touched by this block.

Top module: `seq_run_supervisor`

## Requirements
- R1: `status_o` is one-hot with bit 0 = stopped, bit 1 = reset, bit 2 = running, bit 3 = waiting. After `rst_ni` is released the value is 4'b0010 and `run_o` is low.
- R2: Each hardware line passes through a two-flop synchroniser, and action is taken only on a detected high-to-low transition. A trigger first sampled low at clock edge k takes effect at edge k+2. A line held low acts once.
- R3: In the reset or stopped state, a software start or a trigger falling edge with `prog_done_i` high enters running. It raises `restart_o` for exactly one cycle, in the first running cycle.
- R4: While `prog_done_i` is low, neither a software start nor a trigger leaves the reset or stopped state.
- R5: In running, `seq_wait_i` enters waiting. In waiting, a trigger falling edge or a software start returns to running and raises `resume_o` for one cycle. `restart_o` stays low on that transition.
- R6: In running, `seq_stop_i` enters stopped. If it arrives together with `seq_wait_i`, stop wins.
- R7: A hardware-reset falling edge in any state enters the reset state. The next accepted start restarts from address zero (`restart_o` pulses).
- R8: A software stop in running or waiting enters stopped. `analog_en_o` is high only in running and waiting.
- R9: When hardware reset and trigger falling edges are detected in the same cycle, the result is the reset state.
- R10: A trigger falling edge in running changes nothing.
- R11: `restart_o` and `resume_o` are never high together, and neither is high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_start_i | input | 1 | Software start pulse |
| sw_stop_i | input | 1 | Software stop pulse |
| hw_trig_ni | input | 1 | Hardware trigger, active low, asynchronous |
| hw_rst_ni | input | 1 | Hardware reset, active low, asynchronous |
| prog_done_i | input | 1 | Program store complete |
| seq_wait_i | input | 1 | Sequencer reached a wait instruction |
| seq_stop_i | input | 1 | Sequencer reached a stop instruction |
| run_o | output | 1 | Sequencer enable (running or waiting) |
| restart_o | output | 1 | One-cycle command to restart at address zero |
| resume_o | output | 1 | One-cycle command to continue past the wait |
| analog_en_o | output | 1 | Analog output gate |
| status_o | output | 4 | One-hot status: stopped, reset, running, waiting |

## Verification
The trigger is exercised in all four states. From idle it must restart, from waiting it must resume, and in running and stopped-without-program it must do nothing, which separates the state-dependent meaning of one pin. A trigger held low across a second wait shows that one edge acts once, and a sampled-latency check fixes the two-flop delay. Simultaneous reset and trigger edges, stop and wait arriving together, and software stop from waiting check the priority order.

// File: rtl/seq_run_pkg.sv
package seq_run_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_STOP  = 2'd1,
    ST_RUN   = 2'd2,
    ST_WAIT  = 2'd3
  } run_state_e;

  localparam int unsigned STAT_W    = 4;
  localparam int unsigned STAT_STOP = 0;
  localparam int unsigned STAT_RST  = 1;
  localparam int unsigned STAT_RUN  = 2;
  localparam int unsigned STAT_WAIT = 3;
endpackage

// File: rtl/rc_fall_detect.sv
module rc_fall_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic fall_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b1;
          else         chain_q[0] <= pin_ni;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b1;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= chain_q[LAST];
  end

  assign fall_o = prev_q & ~chain_q[LAST];

  // one low period yields one event
  p_single_fire_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/rc_run_fsm.sv
module rc_run_fsm
  import seq_run_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_start_i,
  input  logic       sw_stop_i,
  input  logic       trig_fall_i,
  input  logic       hrst_fall_i,
  input  logic       prog_done_i,
  input  logic       seq_wait_i,
  input  logic       seq_stop_i,
  output run_state_e state_o,
  output logic       restart_o,
  output logic       resume_o
);
  run_state_e state_q, state_d;
  logic       restart_d, resume_d;
  logic       go_req, active;

  assign go_req = sw_start_i | trig_fall_i;
  assign active = (state_q == ST_RUN) || (state_q == ST_WAIT);

  always_comb begin
    state_d   = state_q;
    restart_d = 1'b0;
    resume_d  = 1'b0;
    if (hrst_fall_i) begin
      state_d = ST_RESET;
    end else if (sw_stop_i && active) begin
      state_d = ST_STOP;
    end else begin
      unique case (state_q)
        ST_RESET, ST_STOP: begin
          if (go_req && prog_done_i) begin
            state_d   = ST_RUN;
            restart_d = 1'b1;
          end
        end
        ST_RUN: begin
          if (seq_stop_i)      state_d = ST_STOP;
          else if (seq_wait_i) state_d = ST_WAIT;
        end
        ST_WAIT: begin
          if (go_req) begin
            state_d  = ST_RUN;
            resume_d = 1'b1;
          end
        end
        default: state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RESET;
      restart_q <= 1'b0;
      resume_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_q <= restart_d;
      resume_q  <= resume_d;
    end
  end

  logic restart_q, resume_q;
  assign state_o   = state_q;
  assign restart_o = restart_q;
  assign resume_o  = resume_q;

  p_no_start_unprog_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !prog_done_i) |=> (state_q != ST_RUN));

  p_reset_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hrst_fall_i |=> (state_q == ST_RESET));

  p_run_ignores_trig_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && trig_fall_i && !hrst_fall_i && !sw_stop_i
     && !seq_stop_i && !seq_wait_i) |=> (state_q == ST_RUN));

  p_pulse_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restart_q && resume_q));

  p_restart_short_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_q |=> !restart_q);

  p_resume_from_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_q |-> ($past(state_q) == ST_WAIT && state_q == ST_RUN));
endmodule

// File: rtl/seq_run_supervisor.sv
module seq_run_supervisor
  import seq_run_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_start_i,
  input  logic              sw_stop_i,
  input  logic              hw_trig_ni,
  input  logic              hw_rst_ni,
  input  logic              prog_done_i,
  input  logic              seq_wait_i,
  input  logic              seq_stop_i,
  output logic              run_o,
  output logic              restart_o,
  output logic              resume_o,
  output logic              analog_en_o,
  output logic [STAT_W-1:0] status_o
);
  logic       trig_fall, hrst_fall;
  run_state_e state;

  rc_fall_detect #(.STAGES(SYNC_STAGES)) i_trig_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (hw_trig_ni),
    .fall_o (trig_fall)
  );

  rc_fall_detect #(.STAGES(SYNC_STAGES)) i_hrst_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (hw_rst_ni),
    .fall_o (hrst_fall)
  );

  rc_run_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_start_i  (sw_start_i),
    .sw_stop_i   (sw_stop_i),
    .trig_fall_i (trig_fall),
    .hrst_fall_i (hrst_fall),
    .prog_done_i (prog_done_i),
    .seq_wait_i  (seq_wait_i),
    .seq_stop_i  (seq_stop_i),
    .state_o     (state),
    .restart_o   (restart_o),
    .resume_o    (resume_o)
  );

  always_comb begin
    status_o            = '0;
    status_o[STAT_STOP] = (state == ST_STOP);
    status_o[STAT_RST]  = (state == ST_RESET);
    status_o[STAT_RUN]  = (state == ST_RUN);
    status_o[STAT_WAIT] = (state == ST_WAIT);
  end

  assign run_o       = status_o[STAT_RUN] | status_o[STAT_WAIT];
  assign analog_en_o = run_o;

  p_status_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_o) == 1);

  p_stop_closes_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_stop_i && run_o && !hrst_fall) |=> (!analog_en_o && status_o[STAT_STOP]));

  p_stop_event_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[STAT_RUN] && seq_stop_i && !hrst_fall) |=> status_o[STAT_STOP]);

  p_hw_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restart_o) |-> $past(!run_o));
endmodule

// File: tb/test_seq_run_supervisor.sv
`timescale 1ns/1ps
module test_seq_run_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_start = 0, sw_stop = 0, trig_n = 1, hrst_n = 1;
  logic prog_done = 0, seq_wait = 0, seq_stop = 0;
  logic run, restart, resume, analog_en;
  logic [3:0] status;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seq_run_supervisor i_seq_run_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .sw_start_i(sw_start), .sw_stop_i(sw_stop),
    .hw_trig_ni(trig_n), .hw_rst_ni(hrst_n), .prog_done_i(prog_done),
    .seq_wait_i(seq_wait), .seq_stop_i(seq_stop), .run_o(run),
    .restart_o(restart), .resume_o(resume), .analog_en_o(analog_en),
    .status_o(status)
  );

  // reference model: status as a one-hot integer, input histories as queues
  int m_status;
  bit m_restart, m_resume;
  bit trig_h[$], hrst_h[$];

  function automatic bit fell(ref bit h[$]);
    return h[1] && !h[0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_status = 2; m_restart = 0; m_resume = 0;
      trig_h = '{1, 1, 1}; hrst_h = '{1, 1, 1};
    end else begin
      bit tf, rf;
      // h[0]=newest synced, h[1]=previous synced, h[2]=first stage
      tf = fell(trig_h); rf = fell(hrst_h);
      m_restart = 0; m_resume = 0;
      if (rf) m_status = 2;
      else if (sw_stop && (m_status == 4 || m_status == 8)) m_status = 1;
      else if (m_status == 1 || m_status == 2) begin
        if ((sw_start || tf) && prog_done) begin m_status = 4; m_restart = 1; end
      end else if (m_status == 4) begin
        if (seq_stop) m_status = 1;
        else if (seq_wait) m_status = 8;
      end else if (m_status == 8) begin
        if (sw_start || tf) begin m_status = 4; m_resume = 1; end
      end
      trig_h = '{trig_h[2], trig_h[0], trig_n};
      hrst_h = '{hrst_h[2], hrst_h[0], hrst_n};
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R1 status", status, m_status);
    chk("R3 restart", restart, m_restart);
    chk("R5 resume", resume, m_resume);
    chk("R8 analog gate", analog_en, (m_status == 4 || m_status == 8));
    chk("R8 run", run, (m_status == 4 || m_status == 8));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    sw_start = 1; cyc(1); sw_start = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R1 reset status", status, 4'b0010);
    chk("R1 reset run", run, 0);
    // R4: start without a program
    pulse_start(); cyc(1);
    trig_n = 0; cyc(5); trig_n = 1; cyc(3);
    chk("R4 no start unprogrammed", status, 4'b0010);
    // R3: software start
    prog_done = 1;
    sw_start = 1; cyc(1); sw_start = 0;
    chk("R3 running", status, 4'b0100);
    chk("R3 restart pulse", restart, 1);
    cyc(1);
    chk("R3 restart one cycle", restart, 0);
    // R10: trigger while running is ignored
    trig_n = 0; cyc(6);
    chk("R10 trigger ignored", status, 4'b0100);
    trig_n = 1; cyc(3);
    // R5: wait, then trigger held low resumes once
    seq_wait = 1; cyc(1); seq_wait = 0;
    chk("R5 waiting", status, 4'b1000);
    chk("R5 run stays high", run, 1);
    trig_n = 0; cyc(2);
    chk("R2 not yet", status, 4'b1000);
    cyc(1);
    chk("R5 resumed", status, 4'b0100);
    chk("R5 resume pulse", resume, 1);
    chk("R5 no restart", restart, 0);
    cyc(2);
    seq_wait = 1; cyc(1); seq_wait = 0;
    cyc(5);
    chk("R2 held low acts once", status, 4'b1000);
    trig_n = 1; cyc(3);
    pulse_start();
    chk("R5 sw start resumes", status, 4'b0100);
    // R6: stop event with wait together
    seq_stop = 1; seq_wait = 1; cyc(1); seq_stop = 0; seq_wait = 0;
    chk("R6 stopped", status, 4'b0001);
    chk("R8 gate closed", analog_en, 0);
    // R2/R3: trigger from stopped, latency two edges after first sample
    trig_n = 0; cyc(2);
    chk("R2 latency", status, 4'b0001);
    cyc(1);
    chk("R3 trigger restart", restart, 1);
    trig_n = 1; cyc(4);
    // R7: hardware reset while running
    hrst_n = 0; cyc(3);
    chk("R7 reset state", status, 4'b0010);
    hrst_n = 1; cyc(3);
    trig_n = 0; cyc(3);
    chk("R7 restart after reset", restart, 1);
    trig_n = 1; cyc(3);
    // R8: software stop from waiting
    seq_wait = 1; cyc(1); seq_wait = 0;
    sw_stop = 1; cyc(1); sw_stop = 0;
    chk("R8 stop from wait", status, 4'b0001);
    chk("R8 gate low", analog_en, 0);
    // R9: reset and trigger edges together
    trig_n = 0; hrst_n = 0; cyc(3);
    chk("R9 reset wins", status, 4'b0010);
    trig_n = 1; hrst_n = 1; cyc(4);
    chk("R9 stays reset", status, 4'b0010);
    pulse_start();
    chk("R7 sw start after reset", status, 4'b0100);
    chk("R11 pulses exclusive", restart & resume, 0);
    cyc(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule